// File: doc/BRIEF.md
# Polled Console Port

This block is a console peripheral that sits on the I/O bus of an 8-bit processor. It has two adjacent port addresses. The lower one is a status register for reads and a control register for writes. The upper one is the data register, used for received bytes on a read and for transmitted bytes on a write. On the host side, incoming characters arrive on a valid/ready byte stream. Outgoing characters leave on a second valid/ready stream.

The block does not watch the incoming stream on every clock. A free-running counter opens a sampling slot once every 256 clocks. A pending host byte is taken only in such a slot, and only while the processor has not raised its throttle bit. The byte then waits in the host stream until the processor reads the data port, and that read acknowledges it. A receive-full condition can pull an active-low interrupt line low when the processor has enabled it. Software polls the status register or services the interrupt, reads the byte, and writes characters back out through the same data port.

Top module: `cons_port`

## Requirements
- R1: The status/control register answers only at I/O address 0x80 and the data register only at 0x81. A read of any other address returns 0x00. A write to any other address changes neither the control state nor the transmit stream.
- R2: A status read returns the receive-full flag in bit 0 and transmit-ready in bit 1. Bits 7..2 are zero. Transmit-ready is 1 exactly when no written byte is waiting and `host_tx_ready` is high.
- R3: The sampling counter is zero in the first clock after reset is released and counts up by one on every clock. The receive-full flag can become set only at a clock edge where the counter's low 8 bits are zero, so the slots fall on edges 0, 256, 512 and so on after reset release.
- R4: At a sampling edge, the receive-full flag is set only when the throttle bit is 0 and `host_rx_valid` is 1.
- R5: `irq_n` is low exactly while the receive-full flag is set and the interrupt-enable bit is 1.
- R6: A read of 0x81 while receive-full is set returns `host_rx_data` on `io_rdata` and raises `host_rx_ready` in that same cycle. From the next cycle the flag is clear and `irq_n` is high. A status read does not consume the byte. A read of 0x81 with the flag clear returns 0x00 and does not raise `host_rx_ready`.
- R7: A write to 0x80 loads the control register. Bit 7 is the receive interrupt enable and bit 6 is the throttle. The control value never appears on a status read.
- R8: A write to 0x81 presents the byte on `host_tx_data` with `host_tx_valid` high from the next cycle on. Both hold until a cycle in which `host_tx_ready` is high, and `host_tx_valid` drops after that cycle. A data write made while a byte is still waiting is ignored.
- R9: Synchronous active-high reset clears the control register and both flags, releases `irq_n` high and drops `host_tx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 8 | I/O port address |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_wdata | input | 8 | Write data from the processor |
| io_rdata | output | 8 | Read data to the processor, combinational in the strobe cycle |
| host_rx_valid | input | 1 | Host has a byte for the processor |
| host_rx_data | input | 8 | Host byte, held while valid |
| host_rx_ready | output | 1 | Host byte consumed this cycle |
| host_tx_valid | output | 1 | Byte waiting for the host |
| host_tx_data | output | 8 | Byte for the host |
| host_tx_ready | input | 1 | Host accepts the byte this cycle |
| irq_n | output | 1 | Receive interrupt request, active low |

## Verification
Read data and `host_rx_ready` are combinational, so they are due in the same cycle as the read strobe. The bench samples them 1 ns after it drives the strobe at the falling edge. The receive flag, the interrupt line, the control register and the transmit stream each change one register stage after the causing edge, and the bench checks them at the next falling edge. The bench keeps its own count of rising edges since reset release. It waits for the edge count that the sampling rule predicts before it expects the receive flag. It also checks that the flag stays clear on the non-slot edges in between.

// File: rtl/cons_pkg.sv
package cons_pkg;

    localparam int unsigned DW = 8;

    typedef logic [DW-1:0] byte_t;

    // control register image: bit 7 interrupt enable, bit 6 throttle
    localparam int unsigned CTL_IE_BIT  = 7;
    localparam int unsigned CTL_THR_BIT = 6;

    typedef struct packed {
        logic rx_ie;
        logic rx_thr;
    } ctl_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2
    } sel_e;

    function automatic sel_e port_sel(input byte_t addr, input byte_t base);
        if (addr == base)
            return SEL_STAT;
        else if (addr == byte_t'(base + byte_t'(1)))
            return SEL_DATA;
        else
            return SEL_NONE;
    endfunction

    function automatic ctl_t ctl_from_byte(input byte_t b);
        ctl_t c;
        c.rx_ie  = b[CTL_IE_BIT];
        c.rx_thr = b[CTL_THR_BIT];
        return c;
    endfunction

    function automatic byte_t status_byte(input logic rx_full, input logic tx_rdy);
        return {6'b0, tx_rdy, rx_full};
    endfunction

endpackage

// File: rtl/cons_tick.sv
module cons_tick #(
    parameter int unsigned TICK_LOG2 = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    logic [TICK_LOG2-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == '0);
endmodule

// File: rtl/cons_rx.sv
module cons_rx (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic throttle,
    input  logic rd_data,
    input  logic host_rx_valid,
    output logic host_rx_ready,
    output logic rx_full
);
    logic take;

    assign take          = rd_data && rx_full;
    assign host_rx_ready = take;

    always_ff @(posedge clk) begin
        if (rst)
            rx_full <= 1'b0;
        else if (take)
            rx_full <= 1'b0;
        else if (tick && !throttle && host_rx_valid)
            rx_full <= 1'b1;
    end
endmodule

// File: rtl/cons_tx.sv
module cons_tx
    import cons_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_data,
    input  byte_t wdata,
    input  logic  host_tx_ready,
    output logic  host_tx_valid,
    output byte_t host_tx_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            host_tx_valid <= 1'b0;
            host_tx_data  <= '0;
        end else if (host_tx_valid) begin
            if (host_tx_ready)
                host_tx_valid <= 1'b0;
        end else if (wr_data) begin
            host_tx_valid <= 1'b1;
            host_tx_data  <= wdata;
        end
    end
endmodule

// File: rtl/cons_port.sv
module cons_port
    import cons_pkg::*;
#(
    parameter logic [7:0]  BASE_ADDR = 8'h80,
    parameter int unsigned TICK_LOG2 = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] io_addr,
    input  logic       io_rd,
    input  logic       io_wr,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    input  logic       host_rx_valid,
    input  logic [7:0] host_rx_data,
    output logic       host_rx_ready,
    output logic       host_tx_valid,
    output logic [7:0] host_tx_data,
    input  logic       host_tx_ready,
    output logic       irq_n
);
    sel_e sel;
    ctl_t ctl;
    logic tick;
    logic rx_full;
    logic rd_data;
    logic wr_data;
    logic wr_ctl;
    logic tx_rdy;

    assign sel     = port_sel(io_addr, BASE_ADDR);
    assign rd_data = io_rd && (sel == SEL_DATA);
    assign wr_data = io_wr && (sel == SEL_DATA);
    assign wr_ctl  = io_wr && (sel == SEL_STAT);

    always_ff @(posedge clk) begin
        if (rst)
            ctl <= '0;
        else if (wr_ctl)
            ctl <= ctl_from_byte(io_wdata);
    end

    cons_tick #(.TICK_LOG2(TICK_LOG2)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    cons_rx u_rx (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .throttle      (ctl.rx_thr),
        .rd_data       (rd_data),
        .host_rx_valid (host_rx_valid),
        .host_rx_ready (host_rx_ready),
        .rx_full       (rx_full)
    );

    cons_tx u_tx (
        .clk           (clk),
        .rst           (rst),
        .wr_data       (wr_data),
        .wdata         (io_wdata),
        .host_tx_ready (host_tx_ready),
        .host_tx_valid (host_tx_valid),
        .host_tx_data  (host_tx_data)
    );

    assign tx_rdy = host_tx_ready && !host_tx_valid;

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            unique case (sel)
                SEL_STAT: io_rdata = status_byte(rx_full, tx_rdy);
                SEL_DATA: io_rdata = rx_full ? host_rx_data : '0;
                default:  io_rdata = '0;
            endcase
        end
    end

    assign irq_n = !(rx_full && ctl.rx_ie);
endmodule

// File: rtl/cons_port_chk.sv
module cons_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       rx_full,
    input logic       throttle,
    input logic       host_rx_valid,
    input logic       host_rx_ready,
    input logic       host_tx_valid,
    input logic [7:0] host_tx_data,
    input logic       host_tx_ready,
    input logic       irq_n
);
    // R3: the flag rises only after a sampling slot
    p_set_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> $past(tick));

    // R3: between slots the flag only changes by a consuming read
    p_hold_off_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !host_rx_ready) |=> $stable(rx_full));

    // R4: the flag rises only with throttle clear and a byte pending
    p_set_gated_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> ($past(!throttle) && $past(host_rx_valid)));

    // R6: a consuming read empties the port and releases the interrupt
    p_consume_r6: assert property (@(posedge clk) disable iff (rst)
        host_rx_ready |=> (!rx_full && irq_n));

    // R8: a waiting byte stays put until accepted
    p_tx_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (host_tx_valid && !host_tx_ready) |=> (host_tx_valid && $stable(host_tx_data)));

    // R8: one handshake per written byte
    p_tx_once_r8: assert property (@(posedge clk) disable iff (rst)
        (host_tx_valid && host_tx_ready) |=> !host_tx_valid);

    // R9: quiet outputs straight after reset
    p_reset_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_n && !host_tx_valid && !rx_full));
endmodule

bind cons_port cons_port_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick          (tick),
    .rx_full       (rx_full),
    .throttle      (ctl.rx_thr),
    .host_rx_valid (host_rx_valid),
    .host_rx_ready (host_rx_ready),
    .host_tx_valid (host_tx_valid),
    .host_tx_data  (host_tx_data),
    .host_tx_ready (host_tx_ready),
    .irq_n         (irq_n)
);

// File: tb/cons_port_bench.sv
`timescale 1ns/1ps
module cons_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] io_addr = 8'h00;
    logic       io_rd = 1'b0;
    logic       io_wr = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       host_rx_valid = 1'b0;
    logic [7:0] host_rx_data = 8'h00;
    logic       host_rx_ready;
    logic       host_tx_valid;
    logic [7:0] host_tx_data;
    logic       host_tx_ready = 1'b1;
    logic       irq_n;

    int total = 0;
    int bad   = 0;
    int unsigned cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cons_port u_cons_port (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .host_rx_valid(host_rx_valid),
        .host_rx_data(host_rx_data), .host_rx_ready(host_rx_ready),
        .host_tx_valid(host_tx_valid), .host_tx_data(host_tx_data),
        .host_tx_ready(host_tx_ready), .irq_n(irq_n)
    );

    // rising edges since reset release; the next edge samples when cyc%256==0
    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [7:0] a, output logic [7:0] d, output logic rdy);
        io_addr = a; io_rd = 1'b1;
        #1;
        d = io_rdata; rdy = host_rx_ready;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic to_slot();
        while (cyc % 256 != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d; logic r;
        chk(irq_n == 1'b1, "R9 irq_n", irq_n, 1);
        chk(host_tx_valid == 1'b0, "R9 tx_valid", host_tx_valid, 0);
        io_read(8'h80, d, r);
        chk(d == 8'h02, "R9/R2 status", d, 8'h02);
        io_read(8'h81, d, r);
        chk(d == 8'h00 && r == 1'b0, "R6 empty data read", {r, d}, 0);
    endtask

    task automatic t_rx_basic();
        logic [7:0] d; logic r;
        host_rx_data = 8'h5A; host_rx_valid = 1'b1;
        repeat (3) @(negedge clk);
        io_read(8'h80, d, r);
        chk(d[0] == 1'b0, "R3 no sample off slot", d, 8'h02);
        to_slot();
        io_read(8'h80, d, r);
        chk(d == 8'h03, "R2/R3 status after slot", d, 8'h03);
        chk(r == 1'b0, "R6 status read keeps byte", r, 0);
        chk(irq_n == 1'b1, "R5 irq off when disabled", irq_n, 1);
        io_read(8'h81, d, r);
        chk(d == 8'h5A, "R6 data", d, 8'h5A);
        chk(r == 1'b1, "R6 rx_ready", r, 1);
        host_rx_valid = 1'b0;
        io_read(8'h80, d, r);
        chk(d == 8'h02, "R6 flag cleared", d, 8'h02);
    endtask

    task automatic t_throttle_irq();
        logic [7:0] d; logic r;
        io_write(8'h80, 8'h40);
        host_rx_data = 8'hC3; host_rx_valid = 1'b1;
        to_slot();
        io_read(8'h80, d, r);
        chk(d[0] == 1'b0, "R4 throttled", d, 8'h02);
        chk(irq_n == 1'b1, "R4 irq idle", irq_n, 1);
        io_write(8'h80, 8'hC0);
        io_read(8'h80, d, r);
        chk(d == 8'h02, "R7 control not in status", d, 8'h02);
        io_write(8'h80, 8'h80);
        to_slot();
        chk(irq_n == 1'b0, "R5 irq asserted", irq_n, 0);
        io_read(8'h81, d, r);
        chk(d == 8'hC3 && r, "R6 data under irq", d, 8'hC3);
        host_rx_valid = 1'b0;
        chk(irq_n == 1'b1, "R6 irq released", irq_n, 1);
        to_slot();
        io_read(8'h80, d, r);
        chk(d[0] == 1'b0, "R4 no byte pending", d, 8'h02);
        io_write(8'h80, 8'h00);
    endtask

    task automatic t_tx();
        logic [7:0] d; logic r;
        host_tx_ready = 1'b0;
        io_write(8'h81, 8'hA5);
        chk(host_tx_valid && host_tx_data == 8'hA5, "R8 presented", host_tx_data, 8'hA5);
        io_read(8'h80, d, r);
        chk(d[1] == 1'b0, "R2 tx busy", d, 8'h00);
        io_write(8'h81, 8'h11);
        chk(host_tx_valid && host_tx_data == 8'hA5, "R8 write while busy ignored", host_tx_data, 8'hA5);
        host_tx_ready = 1'b1;
        #1;
        chk(host_tx_valid && host_tx_data == 8'hA5, "R8 held to accept", host_tx_data, 8'hA5);
        @(negedge clk);
        chk(host_tx_valid == 1'b0, "R8 dropped after accept", host_tx_valid, 0);
        @(negedge clk);
        chk(host_tx_valid == 1'b0, "R8 single transfer", host_tx_valid, 0);
    endtask

    task automatic t_other_addr();
        logic [7:0] d; logic r;
        io_write(8'h7F, 8'hC0);
        io_write(8'h82, 8'h77);
        chk(host_tx_valid == 1'b0, "R1 no tx from 0x82", host_tx_valid, 0);
        host_rx_data = 8'h3C; host_rx_valid = 1'b1;
        to_slot();
        io_read(8'h80, d, r);
        chk(d == 8'h03, "R1 throttle not loaded", d, 8'h03);
        chk(irq_n == 1'b1, "R1 enable not loaded", irq_n, 1);
        io_read(8'h82, d, r);
        chk(d == 8'h00 && r == 1'b0, "R1 foreign read", {r, d}, 0);
        io_read(8'h81, d, r);
        chk(d == 8'h3C && r, "R1 byte still there", d, 8'h3C);
        host_rx_valid = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rx_basic();
        t_throttle_irq();
        t_tx();
        t_other_addr();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule